// File: doc/BRIEF.md
# Accumulator ALU with Carry, Zero and Sign Flags

This block is the arithmetic and logic stage of a small fixed-point signal processor. It reads a low accumulator word, a high accumulator extension, and a two-part product register. On a clock edge where an operation is issued, it computes a result and updates three flags. Logic, add, subtract, shift and rotate operations work on the low accumulator word and the low product word. One double-width add works on the full accumulator and the full product.

The operation arrives as a 4-bit code together with a valid strobe. The result and the flags are held in registers. They change only on an edge where the strobe is high and the code names a real operation. This lets the surrounding sequencer issue an operation every cycle, or leave gaps between operations.

Top module: `dsp_acc_alu`

## Requirements
- R1: Synchronous active-high reset clears `result` to 0 and clears `carry`, `zero` and `sign` to 0. When reset and an issued operation fall on the same edge, reset wins.
- R2: Codes 1, 2 and 3 (AND, OR, XOR) combine `acl` bitwise with `pl`. The 32-bit outcome lands in `result[31:0]`, `result[47:32]` becomes 0, and `carry` becomes 0.
- R3: Code 4 (ADD) puts `acl + pl` in `result[31:0]` and 0 in `result[47:32]`. `carry` takes the carry out of bit 31.
- R4: Code 5 (SUB) puts `acl - pl` in `result[31:0]` and 0 in `result[47:32]`. `carry` is 1 exactly when a borrow occurs, that is, when `acl` is less than `pl` as unsigned numbers.
- R5: Code 6 (double-width add) puts `{ach,acl} + {ph,pl}` in all 48 bits of `result`. `carry` takes the carry out of bit 47.
- R6: Code 7 (shift right) moves `acl` right by one bit and inserts 0 at bit 31. Code 8 (rotate right) moves `acl` right by one bit and wraps bit 0 into bit 31. For both codes, `carry` takes the old bit 0 and `result[47:32]` is 0.
- R7: Code 9 (shift left) moves `acl` left by one bit and inserts 0 at bit 0. Code 10 (rotate left) moves `acl` left by one bit and wraps bit 31 into bit 0. For both codes, `carry` takes the old bit 31 and `result[47:32]` is 0.
- R8: Code 11 (byte rotate) rotates `acl` left by 8 bits. `carry` takes bit 24 of the operand, and `result[47:32]` is 0.
- R9: For 32-bit operations (codes 1 to 5 and 7 to 11), `zero` is set when `result[31:0]` is all zeros and `sign` copies `result[31]`. For code 6, `zero` tests all 48 bits and `sign` copies `result[47]`.
- R10: `result` and all three flags keep their values across an edge in any of three cases: `op_valid` is low, the code is 0 (NOP), or the code is one of the unassigned values 12 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe for `op_code` |
| op_code | input | 4 | Operation code (see requirements) |
| acl | input | 32 | Low accumulator word |
| ach | input | 16 | High accumulator extension |
| pl | input | 32 | Low product word |
| ph | input | 16 | High product word |
| result | output | 48 | Registered result |
| carry | output | 1 | Registered carry or borrow flag |
| zero | output | 1 | Registered zero flag |
| sign | output | 1 | Registered sign flag |

## Verification
Two functions can claim the same edge. A synchronous reset can arrive on the same edge as an issued operation, and a hold case (NOP, a strobe held low, or an unassigned code) can follow directly after an operation that changed the outputs. The bench provokes the first by raising reset and the strobe together while the operands would give a nonzero result with carry set, and it expects all outputs cleared. It provokes the second by issuing an operation that sets carry and a nonzero result, then changing the operands and presenting each hold case. After each one it expects the earlier result and flags unchanged.

// File: rtl/dsp_acc_alu_pkg.sv
package dsp_acc_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_ADDW = 4'd6,
    OP_SHR  = 4'd7,
    OP_ROR  = 4'd8,
    OP_SHL  = 4'd9,
    OP_ROL  = 4'd10,
    OP_ROLB = 4'd11
  } alu_op_e;

  function automatic logic op_is_logic(input logic [OP_W-1:0] code);
    return (code == OP_AND) || (code == OP_OR) || (code == OP_XOR);
  endfunction

  function automatic logic op_is_hold(input logic [OP_W-1:0] code);
    return (code == OP_NOP) || (code > OP_ROLB);
  endfunction
endpackage

// File: rtl/dsp_acc_alu_core.sv
module dsp_acc_alu_core
  import dsp_acc_alu_pkg::*;
#(
  parameter int LOW_W  = 32,
  parameter int HIGH_W = 16,
  parameter int ROT_B  = 8
) (
  input  logic [OP_W-1:0]         op_code,
  input  logic [LOW_W-1:0]        acl,
  input  logic [HIGH_W-1:0]       ach,
  input  logic [LOW_W-1:0]        pl,
  input  logic [HIGH_W-1:0]       ph,
  output logic [LOW_W+HIGH_W-1:0] res,
  output logic                    cy,
  output logic                    wide,
  output logic                    hold
);
  localparam int FULL_W = LOW_W + HIGH_W;

  logic [LOW_W:0]  sum_n;
  logic [LOW_W:0]  dif_n;
  logic [FULL_W:0] sum_w;
  logic [LOW_W-1:0] narrow;
  logic             narrow_cy;

  assign sum_n = {1'b0, acl} + {1'b0, pl};
  assign dif_n = {1'b0, acl} - {1'b0, pl};
  assign sum_w = {1'b0, ach, acl} + {1'b0, ph, pl};

  always_comb begin
    narrow    = '0;
    narrow_cy = 1'b0;
    wide      = 1'b0;
    hold      = 1'b0;
    case (op_code)
      OP_AND:  narrow = acl & pl;
      OP_OR:   narrow = acl | pl;
      OP_XOR:  narrow = acl ^ pl;
      OP_ADD:  {narrow_cy, narrow} = sum_n;
      OP_SUB:  {narrow_cy, narrow} = dif_n;
      OP_ADDW: wide = 1'b1;
      OP_SHR: begin
        narrow    = {1'b0, acl[LOW_W-1:1]};
        narrow_cy = acl[0];
      end
      OP_ROR: begin
        narrow    = {acl[0], acl[LOW_W-1:1]};
        narrow_cy = acl[0];
      end
      OP_SHL: begin
        narrow    = {acl[LOW_W-2:0], 1'b0};
        narrow_cy = acl[LOW_W-1];
      end
      OP_ROL: begin
        narrow    = {acl[LOW_W-2:0], acl[LOW_W-1]};
        narrow_cy = acl[LOW_W-1];
      end
      OP_ROLB: begin
        narrow    = {acl[LOW_W-ROT_B-1:0], acl[LOW_W-1:LOW_W-ROT_B]};
        narrow_cy = acl[LOW_W-ROT_B];
      end
      default: hold = 1'b1;
    endcase
  end

  assign res = wide ? sum_w[FULL_W-1:0] : {{HIGH_W{1'b0}}, narrow};
  assign cy  = wide ? sum_w[FULL_W] : narrow_cy;
endmodule

// File: rtl/dsp_acc_alu_flags.sv
module dsp_acc_alu_flags #(
  parameter int LOW_W  = 32,
  parameter int HIGH_W = 16
) (
  input  logic [LOW_W+HIGH_W-1:0] res,
  input  logic                    wide,
  output logic                    zf,
  output logic                    sf
);
  localparam int FULL_W = LOW_W + HIGH_W;

  logic z_n, z_w;
  assign z_n = (res[LOW_W-1:0] == '0);
  assign z_w = z_n && (res[FULL_W-1:LOW_W] == '0);
  assign zf  = wide ? z_w : z_n;
  assign sf  = wide ? res[FULL_W-1] : res[LOW_W-1];
endmodule

// File: rtl/dsp_acc_alu.sv
module dsp_acc_alu
  import dsp_acc_alu_pkg::*;
#(
  parameter int LOW_W  = 32,
  parameter int HIGH_W = 16,
  parameter int ROT_B  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    op_valid,
  input  logic [OP_W-1:0]         op_code,
  input  logic [LOW_W-1:0]        acl,
  input  logic [HIGH_W-1:0]       ach,
  input  logic [LOW_W-1:0]        pl,
  input  logic [HIGH_W-1:0]       ph,
  output logic [LOW_W+HIGH_W-1:0] result,
  output logic                    carry,
  output logic                    zero,
  output logic                    sign
);
  localparam int FULL_W = LOW_W + HIGH_W;

  logic [FULL_W-1:0] c_res;
  logic              c_cy, c_wide, c_hold, c_zf, c_sf;

  dsp_acc_alu_core #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .ROT_B(ROT_B)) u_core (
    .op_code (op_code),
    .acl     (acl),
    .ach     (ach),
    .pl      (pl),
    .ph      (ph),
    .res     (c_res),
    .cy      (c_cy),
    .wide    (c_wide),
    .hold    (c_hold)
  );

  dsp_acc_alu_flags #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_flags (
    .res  (c_res),
    .wide (c_wide),
    .zf   (c_zf),
    .sf   (c_sf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      carry  <= 1'b0;
      zero   <= 1'b0;
      sign   <= 1'b0;
    end else if (op_valid && !c_hold) begin
      result <= c_res;
      carry  <= c_cy;
      zero   <= c_zf;
      sign   <= c_sf;
    end
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry && !zero && !sign));

  p_logic_no_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_is_logic(op_code)) |=> !carry);

  p_add_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ADD) |=>
      ({carry, result[LOW_W-1:0]} == ({1'b0, $past(acl)} + {1'b0, $past(pl)})));

  p_borrow_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SUB) |=> (carry == ($past(acl) < $past(pl))));

  p_wide_add_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ADDW) |=>
      ({carry, result} == ({1'b0, $past(ach), $past(acl)} + {1'b0, $past(ph), $past(pl)})));

  p_right_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_SHR || op_code == OP_ROR)) |=> (carry == $past(acl[0])));

  p_left_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_SHL || op_code == OP_ROL)) |=> (carry == $past(acl[LOW_W-1])));

  p_byte_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ROLB) |=> (carry == $past(acl[LOW_W-ROT_B])));

  p_zero_means_empty_r9: assert property (@(posedge clk) disable iff (rst)
    zero |-> (result == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_is_hold(op_code)) |=>
      ($stable(result) && $stable(carry) && $stable(zero) && $stable(sign)));
endmodule

// File: tb/dsp_acc_alu_test.sv
module dsp_acc_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] acl = '0;
  logic [15:0] ach = '0;
  logic [31:0] pl = '0;
  logic [15:0] ph = '0;
  logic [47:0] result;
  logic        carry, zero, sign;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  dsp_acc_alu uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .acl(acl), .ach(ach), .pl(pl), .ph(ph),
    .result(result), .carry(carry), .zero(zero), .sign(sign)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [3:0]  op;
    logic [31:0] a_lo;
    logic [15:0] a_hi;
    logic [31:0] p_lo;
    logic [15:0] p_hi;
    logic [47:0] res;
    logic        c, z, s;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{"R2 ", 4'd1,  32'hF0F0_F0F0, 16'hFFFF, 32'hFF00_FF00, 16'hFFFF, 48'h0000_F000_F000, 1'b0, 1'b0, 1'b1},
    '{"R2 ", 4'd2,  32'h0000_00FF, 16'h0000, 32'h0000_FF00, 16'h0000, 48'h0000_0000_FFFF, 1'b0, 1'b0, 1'b0},
    '{"R9 ", 4'd3,  32'h1234_5678, 16'h0000, 32'h1234_5678, 16'h0000, 48'h0,              1'b0, 1'b1, 1'b0},
    '{"R3 ", 4'd4,  32'hFFFF_FFFF, 16'h0000, 32'h0000_0001, 16'h0000, 48'h0,              1'b1, 1'b1, 1'b0},
    '{"R3 ", 4'd4,  32'h7FFF_FFFF, 16'h0000, 32'h0000_0001, 16'h0000, 48'h0000_8000_0000, 1'b0, 1'b0, 1'b1},
    '{"R4 ", 4'd5,  32'h0000_0005, 16'h0000, 32'h0000_0003, 16'h0000, 48'h0000_0000_0002, 1'b0, 1'b0, 1'b0},
    '{"R4 ", 4'd5,  32'h0000_0003, 16'h0000, 32'h0000_0005, 16'h0000, 48'h0000_FFFF_FFFE, 1'b1, 1'b0, 1'b1},
    '{"R5 ", 4'd6,  32'hFFFF_FFFF, 16'h0001, 32'h0000_0001, 16'h0000, 48'h0002_0000_0000, 1'b0, 1'b0, 1'b0},
    '{"R5 ", 4'd6,  32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0001, 16'h0000, 48'h0,              1'b1, 1'b1, 1'b0},
    '{"R9 ", 4'd6,  32'hFFFF_FFFF, 16'h7FFF, 32'h0000_0001, 16'h0000, 48'h8000_0000_0000, 1'b0, 1'b0, 1'b1},
    '{"R6 ", 4'd7,  32'h8000_0001, 16'h0000, 32'h0000_0000, 16'h0000, 48'h0000_4000_0000, 1'b1, 1'b0, 1'b0},
    '{"R6 ", 4'd8,  32'h8000_0001, 16'h0000, 32'h0000_0000, 16'h0000, 48'h0000_C000_0000, 1'b1, 1'b0, 1'b1},
    '{"R7 ", 4'd9,  32'h8000_0001, 16'h0000, 32'h0000_0000, 16'h0000, 48'h0000_0000_0002, 1'b1, 1'b0, 1'b0},
    '{"R7 ", 4'd10, 32'h8000_0001, 16'h0000, 32'h0000_0000, 16'h0000, 48'h0000_0000_0003, 1'b1, 1'b0, 1'b0},
    '{"R8 ", 4'd11, 32'h1234_5678, 16'h0000, 32'h0000_0000, 16'h0000, 48'h0000_3456_7812, 1'b0, 1'b0, 1'b0},
    '{"R8 ", 4'd11, 32'h0100_0080, 16'h0000, 32'h0000_0000, 16'h0000, 48'h0000_0000_8001, 1'b1, 1'b0, 1'b0},
    '{"R6 ", 4'd7,  32'h0000_0001, 16'h0000, 32'h0000_0000, 16'h0000, 48'h0,              1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [50:0] got, input logic [50:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got res=%h c=%b z=%b s=%b, expected res=%h c=%b z=%b s=%b",
               tag, got[50:3], got[2], got[1], got[0], exp[50:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // Driven on a falling edge; registered outputs are read one falling edge later.
  task automatic issue(input logic v, input logic [3:0] op, input logic [31:0] a_lo,
                       input logic [15:0] a_hi, input logic [31:0] p_lo, input logic [15:0] p_hi);
    op_valid = v; op_code = op; acl = a_lo; ach = a_hi; pl = p_lo; ph = p_hi;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin : watchdog
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [50:0] snap;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {result, carry, zero, sign}, 51'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VECS[i].op, VECS[i].a_lo, VECS[i].a_hi, VECS[i].p_lo, VECS[i].p_hi);
      check(string'(VECS[i].tag), {result, carry, zero, sign},
            {VECS[i].res, VECS[i].c, VECS[i].z, VECS[i].s});
    end

    // R10: holds after an operation that set carry and a nonzero result
    issue(1'b1, 4'd5, 32'h0000_0003, 16'h0, 32'h0000_0005, 16'h0);
    snap = {48'h0000_FFFF_FFFE, 1'b1, 1'b0, 1'b1};
    check("R4 setup", {result, carry, zero, sign}, snap);
    issue(1'b1, 4'd0, 32'h1111_1111, 16'h2222, 32'h3333_3333, 16'h4444);
    check("R10 nop", {result, carry, zero, sign}, snap);
    issue(1'b0, 4'd4, 32'hFFFF_FFFF, 16'h0, 32'h0000_0001, 16'h0);
    check("R10 strobe low", {result, carry, zero, sign}, snap);
    issue(1'b1, 4'd13, 32'hFFFF_FFFF, 16'hFFFF, 32'hFFFF_FFFF, 16'hFFFF);
    check("R10 code 13", {result, carry, zero, sign}, snap);
    issue(1'b1, 4'd15, 32'h0, 16'h0, 32'h0, 16'h0);
    check("R10 code 15", {result, carry, zero, sign}, snap);

    // R1: reset and issue on the same edge
    rst = 1'b1;
    issue(1'b1, 4'd4, 32'hFFFF_FFFF, 16'h0, 32'h0000_0002, 16'h0);
    check("R1 reset wins", {result, carry, zero, sign}, 51'h0);
    rst = 1'b0;
    issue(1'b1, 4'd4, 32'hFFFF_FFFF, 16'h0, 32'h0000_0002, 16'h0);
    check("R3 after reset", {result, carry, zero, sign}, {48'h0000_0000_0001, 1'b1, 1'b0, 1'b0});

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule